// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves one data item per bus grant between a peripheral and memory without processor involvement. A processor sets it up through a byte-wide register port. It writes a 16-bit start address and a 16-bit transfer count, one byte at a time, through a byte pointer that both registers share. It also writes a 4-bit page value, a mode byte, and a mask bit that arms or disarms the channel. Once the channel is armed, a peripheral request together with a bus grant produces one active-low acknowledge pulse. Each pulse comes with the physical address, a direction strobe and, on the final item, a terminal-count flag.

The count register holds the number of transfers minus one, and the block ends when the remaining count wraps past zero. In single-transfer mode the acknowledge never lasts more than one cycle, so a request held high still leaves every other bus cycle free for the processor. At the end of a block the channel either disarms itself or reloads its start address and count from shadow copies and keeps going.

Top module: `dma_channel_engine`

## Requirements
- R1: After reset `dack_n` is 1, `tc`, `to_mem` and `from_mem` are 0, `bus_addr` is 0 and the channel is masked, so a request with grant produces no acknowledge.
- R2: Register port codes on `reg_sel` are: 0 start address, 1 count, 2 mask, 3 mode, 4 byte-pointer clear, 5 page. Every write to code 0 or 1 loads the low byte when the shared pointer is 0 and the high byte when it is 1, then toggles the pointer. A write to code 4 sets the pointer to 0.
- R3: A mask write takes bit 2 as the new mask value and bits 1:0 as the channel number. It is ignored unless bits 1:0 equal `CHAN_ID` (default 1). While masked, the channel ignores its request.
- R4: Mode byte fields are: bits 1:0 channel (the write is ignored unless they equal `CHAN_ID`), bits 3:2 transfer type (01 to memory, 10 from memory), bit 4 auto-reload, bit 5 address decrement, bits 7:6 service (01 single). Transfers happen only with service 01 and type 01 or 10.
- R5: `dack_n` goes low for exactly one cycle per transfer. With request and grant held high, acknowledges come on every other cycle.
- R6: `dack_n` goes low only in the cycle after one in which `dreq` and `bus_grant` were high and the channel was unmasked.
- R7: A programmed count of N-1 yields N acknowledges per block, and `tc` is 1 with the Nth only.
- R8: With auto-reload off, the channel masks itself at terminal count and gives no further acknowledges. A processor unmask write in that same cycle loses to the self-mask.
- R9: With auto-reload on, at terminal count the current address and count reload from the programmed values and transfers continue.
- R10: `bus_addr[15:0]` shows the current address with each acknowledge and then steps by +1, or by -1 when decrementing, wrapping modulo 2^16. `to_mem` or `from_mem` pulses with the acknowledge according to the type.
- R11: `bus_addr[19:16]` comes from the page register and is not changed by address wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_sel | input | 3 | Register port code |
| reg_wdata | input | 8 | Register write byte |
| dreq | input | 1 | Peripheral transfer request |
| bus_grant | input | 1 | Bus released by the processor |
| dack_n | output | 1 | Active-low transfer acknowledge |
| tc | output | 1 | Terminal count, with the last acknowledge |
| bus_addr | output | 20 | Physical address of the current transfer |
| to_mem | output | 1 | Transfer writes memory |
| from_mem | output | 1 | Transfer reads memory |

## Verification
The assertions check the following on every cycle: each acknowledge lasts a single cycle, each acknowledge is preceded by an armed request and grant, `tc` never appears without an acknowledge, the channel is self-masked or reloaded after `tc` as the mode requires, and the page bits match the page register. The ordering of address bytes through the shared pointer, the ignoring of writes for other channels, the exact number of transfers per block, address wraparound and the sequence of addresses can only be shown by the bench scenarios. Those scenarios compare every acknowledge against addresses computed from the programmed values.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [2:0] {
    PORT_BASE   = 3'd0,
    PORT_COUNT  = 3'd1,
    PORT_MASK   = 3'd2,
    PORT_MODE   = 3'd3,
    PORT_PTRCLR = 3'd4,
    PORT_PAGE   = 3'd5
  } port_e;

  typedef enum logic [1:0] {
    XT_NONE     = 2'b00,
    XT_TO_MEM   = 2'b01,
    XT_FROM_MEM = 2'b10,
    XT_ILLEGAL  = 2'b11
  } xtype_e;

  typedef struct packed {
    logic [1:0] service;
    logic       step_down;
    logic       auto_reload;
    xtype_e     xtype;
  } mode_t;

  localparam logic [1:0] SVC_SINGLE = 2'b01;
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PAGE_W  = 4,
  parameter int CSEL_W  = 2,
  parameter int CHAN_ID = 1,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              tc_mask_set,
  output logic [WORD_W-1:0] base_addr,
  output logic [WORD_W-1:0] base_cnt,
  output logic              addr_wr,
  output logic              cnt_wr,
  output logic              wr_hi,
  output mode_t             mode_q,
  output logic              masked,
  output logic [PAGE_W-1:0] page_q
);
  localparam int MASK_BIT = CSEL_W;
  localparam int MODE_LSB = CSEL_W;
  localparam logic [CSEL_W-1:0] MY_CHAN = CSEL_W'(CHAN_ID);

  logic ptr_hi;
  logic chan_hit;
  logic mask_wr, mode_wr, clr_wr, page_wr;

  assign chan_hit = (wdata[CSEL_W-1:0] == MY_CHAN);
  assign addr_wr  = wr_en && (port_e'(sel) == PORT_BASE);
  assign cnt_wr   = wr_en && (port_e'(sel) == PORT_COUNT);
  assign mask_wr  = wr_en && (port_e'(sel) == PORT_MASK) && chan_hit;
  assign mode_wr  = wr_en && (port_e'(sel) == PORT_MODE) && chan_hit;
  assign clr_wr   = wr_en && (port_e'(sel) == PORT_PTRCLR);
  assign page_wr  = wr_en && (port_e'(sel) == PORT_PAGE);
  assign wr_hi    = ptr_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_hi    <= 1'b0;
      base_addr <= '0;
      base_cnt  <= '0;
      mode_q    <= '0;
      masked    <= 1'b1;
      page_q    <= '0;
    end else begin
      if (clr_wr)                ptr_hi <= 1'b0;
      else if (addr_wr || cnt_wr) ptr_hi <= ~ptr_hi;

      if (addr_wr) begin
        if (ptr_hi) base_addr[WORD_W-1:BYTE_W] <= wdata;
        else        base_addr[BYTE_W-1:0]      <= wdata;
      end
      if (cnt_wr) begin
        if (ptr_hi) base_cnt[WORD_W-1:BYTE_W] <= wdata;
        else        base_cnt[BYTE_W-1:0]      <= wdata;
      end

      if (mode_wr) mode_q <= mode_t'(wdata[MODE_LSB +: $bits(mode_t)]);

      // terminal-count self-mask has priority over a processor write
      if (tc_mask_set)  masked <= 1'b1;
      else if (mask_wr) masked <= wdata[MASK_BIT];

      if (page_wr) page_q <= wdata[PAGE_W-1:0];
    end
  end
endmodule

// File: rtl/dmac_walk.sv
module dmac_walk #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              addr_wr,
  input  logic              cnt_wr,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] base_addr,
  input  logic [WORD_W-1:0] base_cnt,
  input  logic              step,
  input  logic              step_down,
  input  logic              auto_reload,
  output logic [WORD_W-1:0] cur_addr,
  output logic [WORD_W-1:0] cur_cnt,
  output logic              last
);
  assign last = (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
    end else begin
      if (step) begin
        if (last && auto_reload) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
        end else begin
          cur_addr <= step_down ? cur_addr - 1'b1 : cur_addr + 1'b1;
          cur_cnt  <= cur_cnt - 1'b1;
        end
      end
      // processor writes land in the working copy as well
      if (addr_wr) begin
        if (wr_hi) cur_addr[WORD_W-1:BYTE_W] <= wdata;
        else       cur_addr[BYTE_W-1:0]      <= wdata;
      end
      if (cnt_wr) begin
        if (wr_hi) cur_cnt[WORD_W-1:BYTE_W] <= wdata;
        else       cur_cnt[BYTE_W-1:0]      <= wdata;
      end
    end
  end
endmodule

// File: rtl/dmac_xfer.sv
module dmac_xfer
  import dmac_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int PAGE_W = 4,
  localparam int PHYS_W = WORD_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dreq,
  input  logic              grant,
  input  logic              masked,
  input  logic [1:0]        service,
  input  xtype_e            xtype,
  input  logic              auto_reload,
  input  logic              last,
  input  logic [WORD_W-1:0] cur_addr,
  input  logic [PAGE_W-1:0] page,
  output logic              fire,
  output logic              tc_mask_set,
  output logic              dack_n,
  output logic              tc,
  output logic [PHYS_W-1:0] bus_addr,
  output logic              to_mem,
  output logic              from_mem
);
  logic type_ok;

  assign type_ok     = (xtype == XT_TO_MEM) || (xtype == XT_FROM_MEM);
  // dack_n high means the previous cycle was idle: forces a gap cycle
  assign fire        = !masked && (service == SVC_SINGLE) && type_ok &&
                       dreq && grant && dack_n;
  assign tc_mask_set = fire && last && !auto_reload;

  always_ff @(posedge clk) begin
    if (rst) begin
      dack_n   <= 1'b1;
      tc       <= 1'b0;
      bus_addr <= '0;
      to_mem   <= 1'b0;
      from_mem <= 1'b0;
    end else begin
      dack_n   <= ~fire;
      tc       <= fire && last;
      to_mem   <= fire && (xtype == XT_TO_MEM);
      from_mem <= fire && (xtype == XT_FROM_MEM);
      if (fire) bus_addr <= {page, cur_addr};
    end
  end
endmodule

// File: rtl/dma_channel_engine.sv
module dma_channel_engine
  import dmac_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PAGE_W  = 4,
  parameter int CSEL_W  = 2,
  parameter int CHAN_ID = 1,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int PHYS_W = WORD_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              dreq,
  input  logic              bus_grant,
  output logic              dack_n,
  output logic              tc,
  output logic [PHYS_W-1:0] bus_addr,
  output logic              to_mem,
  output logic              from_mem
);
  logic [WORD_W-1:0] base_addr, base_cnt, cur_addr, cur_cnt;
  logic              addr_wr, cnt_wr, wr_hi;
  logic              masked, last, fire, tc_mask_set;
  logic [PAGE_W-1:0] page_q;
  mode_t             mode_q;
  logic              mode_auto;

  assign mode_auto = mode_q.auto_reload;

  dmac_regs #(
    .BYTE_W(BYTE_W), .PAGE_W(PAGE_W), .CSEL_W(CSEL_W), .CHAN_ID(CHAN_ID)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .tc_mask_set(tc_mask_set), .base_addr(base_addr), .base_cnt(base_cnt),
    .addr_wr(addr_wr), .cnt_wr(cnt_wr), .wr_hi(wr_hi), .mode_q(mode_q),
    .masked(masked), .page_q(page_q)
  );

  dmac_walk #(.BYTE_W(BYTE_W)) u_walk (
    .clk(clk), .rst(rst), .wdata(reg_wdata), .addr_wr(addr_wr),
    .cnt_wr(cnt_wr), .wr_hi(wr_hi), .base_addr(base_addr),
    .base_cnt(base_cnt), .step(fire), .step_down(mode_q.step_down),
    .auto_reload(mode_auto), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
    .last(last)
  );

  dmac_xfer #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_xfer (
    .clk(clk), .rst(rst), .dreq(dreq), .grant(bus_grant), .masked(masked),
    .service(mode_q.service), .xtype(mode_q.xtype), .auto_reload(mode_auto),
    .last(last), .cur_addr(cur_addr), .page(page_q), .fire(fire),
    .tc_mask_set(tc_mask_set), .dack_n(dack_n), .tc(tc),
    .bus_addr(bus_addr), .to_mem(to_mem), .from_mem(from_mem)
  );
endmodule

// File: rtl/dma_channel_engine_chk.sv
module dma_channel_engine_chk #(
  parameter int WORD_W = 16,
  parameter int PAGE_W = 4,
  localparam int PHYS_W = WORD_W + PAGE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              dreq,
  input logic              bus_grant,
  input logic              dack_n,
  input logic              tc,
  input logic [PHYS_W-1:0] bus_addr,
  input logic              to_mem,
  input logic              from_mem,
  input logic              masked,
  input logic              mode_auto,
  input logic [PAGE_W-1:0] page_q,
  input logic [WORD_W-1:0] cur_addr,
  input logic [WORD_W-1:0] cur_cnt,
  input logic [WORD_W-1:0] base_addr,
  input logic [WORD_W-1:0] base_cnt
);
  a_r5_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !dack_n |=> dack_n);

  a_r6_ack_needs_request: assert property (@(posedge clk) disable iff (rst)
    !dack_n |-> $past(dreq && bus_grant && !masked));

  a_r7_tc_with_ack: assert property (@(posedge clk) disable iff (rst)
    tc |-> !dack_n);

  a_r8_self_mask: assert property (@(posedge clk) disable iff (rst)
    (tc && !$past(mode_auto)) |-> masked);

  a_r9_reload: assert property (@(posedge clk) disable iff (rst)
    (tc && $past(mode_auto)) |-> (cur_cnt == base_cnt && cur_addr == base_addr));

  a_r10_dir_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({to_mem, from_mem}));

  a_r11_page_bits: assert property (@(posedge clk) disable iff (rst)
    !dack_n |-> (bus_addr[PHYS_W-1:WORD_W] == $past(page_q)));
endmodule

bind dma_channel_engine dma_channel_engine_chk #(
  .WORD_W(WORD_W), .PAGE_W(PAGE_W)
) u_chk (
  .clk(clk), .rst(rst), .dreq(dreq), .bus_grant(bus_grant),
  .dack_n(dack_n), .tc(tc), .bus_addr(bus_addr), .to_mem(to_mem),
  .from_mem(from_mem), .masked(masked), .mode_auto(mode_auto),
  .page_q(page_q), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
  .base_addr(base_addr), .base_cnt(base_cnt)
);

// File: tb/tb_dma_channel_engine.sv
module tb_dma_channel_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic        dreq = 1'b0;
  logic        bus_grant = 1'b0;
  logic        dack_n, tc, to_mem, from_mem;
  logic [19:0] bus_addr;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_channel_engine dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dreq(dreq), .bus_grant(bus_grant),
    .dack_n(dack_n), .tc(tc), .bus_addr(bus_addr), .to_mem(to_mem),
    .from_mem(from_mem)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic prog(input logic [15:0] base, input logic [15:0] cnt,
                      input logic [3:0] pg, input logic [7:0] mode);
    wr(3'd4, 8'h00);
    wr(3'd0, base[7:0]);  wr(3'd0, base[15:8]);
    wr(3'd1, cnt[7:0]);   wr(3'd1, cnt[15:8]);
    wr(3'd5, {4'h0, pg});
    wr(3'd3, mode);
  endtask

  task automatic idle_no_ack(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      tick();
      chk(tag, {31'd0, dack_n}, 32'd1);
    end
  endtask

  task automatic run_block(input logic [15:0] base, input int n, input logic [3:0] pg,
                           input bit down, input bit auto, input bit tomem, input int reps);
    logic [7:0]  m;
    logic [15:0] ea;
    int idx;
    m = 8'h41 | (down ? 8'h20 : 8'h00) | (auto ? 8'h10 : 8'h00) | (tomem ? 8'h04 : 8'h08);
    prog(base, 16'(n - 1), pg, m);
    wr(3'd2, 8'h01);
    dreq = 1'b1; bus_grant = 1'b1;
    for (int c = 0; c < 2 * n * reps; c++) begin
      tick();
      if (c % 2 == 0) begin
        idx = (c / 2) % n;
        ea  = down ? base - 16'(idx) : base + 16'(idx);
        chk("R5 ack low", {31'd0, dack_n}, 32'd0);
        chk((auto && c >= 2 * n) ? "R9 reload address" : "R10 R11 address",
            {12'd0, bus_addr}, {12'd0, pg, ea});
        chk("R7 tc on last", {31'd0, tc}, {31'd0, (idx == n - 1)});
        chk("R10 direction", {30'd0, to_mem, from_mem}, {30'd0, tomem, !tomem});
      end else begin
        chk("R5 gap cycle", {31'd0, dack_n}, 32'd1);
      end
    end
    if (!auto) idle_no_ack(6, "R8 self mask");
    @(negedge clk);
    dreq = 1'b0;
    wr(3'd2, 8'h05);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 dack_n reset", {31'd0, dack_n}, 32'd1);
    chk("R1 tc reset", {31'd0, tc}, 32'd0);
    chk("R1 strobes reset", {30'd0, to_mem, from_mem}, 32'd0);
    chk("R1 addr reset", {12'd0, bus_addr}, 32'd0);
    @(negedge clk);
    dreq = 1'b1; bus_grant = 1'b1;
    idle_no_ack(4, "R1 masked after reset");
    @(negedge clk);
    dreq = 1'b0;

    // main sweeps
    run_block(16'h1234, 4, 4'hA, 0, 0, 1, 1);
    run_block(16'h0001, 3, 4'h5, 1, 0, 0, 1);
    run_block(16'hFFFE, 4, 4'h3, 0, 0, 1, 1);
    run_block(16'h8000, 1, 4'hF, 0, 0, 0, 1);
    run_block(16'h0100, 3, 4'h2, 0, 1, 1, 2);
    run_block(16'h0010, 2, 4'h7, 1, 1, 0, 3);

    // R2 shared byte pointer without clearing between registers
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h11); wr(3'd0, 8'h22); wr(3'd0, 8'h33);
    wr(3'd1, 8'h00); wr(3'd1, 8'h02);
    wr(3'd5, 8'h01);
    wr(3'd3, 8'h45);
    wr(3'd2, 8'h01);
    dreq = 1'b1; bus_grant = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R2 pointer ack", {31'd0, dack_n}, 32'd0);
      chk("R2 pointer address", {12'd0, bus_addr}, 32'h12233 + k);
      tick();
    end
    idle_no_ack(4, "R2 pointer count");
    @(negedge clk); dreq = 1'b0;

    // R6 grant withheld
    prog(16'h2000, 16'd1, 4'h4, 8'h45);
    wr(3'd2, 8'h01);
    dreq = 1'b1; bus_grant = 1'b0;
    idle_no_ack(6, "R6 no grant");
    @(negedge clk); bus_grant = 1'b1;
    tick();
    chk("R6 grant given", {31'd0, dack_n}, 32'd0);
    chk("R6 grant addr", {12'd0, bus_addr}, 32'h42000);
    @(negedge clk); dreq = 1'b0;
    wr(3'd2, 8'h05);

    // R3 mask write for another channel, R4 mode write for another channel
    prog(16'h4000, 16'd3, 4'h6, 8'h45);
    wr(3'd2, 8'h02);
    dreq = 1'b1; bus_grant = 1'b1;
    idle_no_ack(4, "R3 other channel unmask");
    @(negedge clk); dreq = 1'b0;
    wr(3'd3, 8'h68);
    wr(3'd2, 8'h01);
    dreq = 1'b1;
    tick();
    chk("R4 first addr", {12'd0, bus_addr}, 32'h64000);
    tick(); tick();
    chk("R4 other mode ignored", {12'd0, bus_addr}, 32'h64001);
    chk("R4 direction kept", {30'd0, to_mem, from_mem}, 32'd2);
    @(negedge clk); dreq = 1'b0;
    wr(3'd2, 8'h05);

    // R4 service and type gating
    prog(16'h3000, 16'd3, 4'h1, 8'h05);
    wr(3'd2, 8'h01);
    dreq = 1'b1;
    idle_no_ack(4, "R4 service not single");
    @(negedge clk); dreq = 1'b0;
    wr(3'd3, 8'h41);
    dreq = 1'b1;
    idle_no_ack(4, "R4 type 00");
    @(negedge clk); dreq = 1'b0;
    wr(3'd3, 8'h4D);
    dreq = 1'b1;
    idle_no_ack(4, "R4 type 11");
    @(negedge clk); dreq = 1'b0;
    wr(3'd2, 8'h05);

    // R8 unmask in the terminal-count cycle loses
    prog(16'h0500, 16'd0, 4'h0, 8'h45);
    wr(3'd2, 8'h01);
    @(negedge clk);
    dreq = 1'b1; bus_grant = 1'b1;
    reg_wr = 1'b1; reg_sel = 3'd2; reg_wdata = 8'h01;
    @(posedge clk); #1;
    chk("R8 tc ack", {30'd0, dack_n, tc}, 32'd1);
    @(negedge clk); reg_wr = 1'b0;
    idle_no_ack(6, "R8 self mask wins");
    @(negedge clk); dreq = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule